// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

This block moves bytes over a three-wire synchronous link: a shift clock, a data output and a data input. Each side of the link is double-buffered. The host writes a byte into a holding register. When the shifter is free and transmit is enabled, the byte moves into the shifter. Eight bits then leave on the data output, least-significant bit first, with no start, stop or parity bits. While those bits go out, eight bits are captured from the data input. The captured byte lands in a receive holding register that the host reads.

The block either makes the shift clock itself or follows a clock driven in from outside. An internal clock comes from a prescaler (divide by 1, 8 or 32) followed by an 8-bit divider. A polarity control picks which clock edge launches data and which edge samples it. The host sees level flags and two sticky interrupt requests. Each request is cleared by a pulse. The transmit request can fire either when the holding register empties or when the shifter finishes a byte.

Every transfer is paced by the transmit side. A byte is shifted only while the shifter holds loaded data. So in external-clock mode the host must write a dummy byte before the remote clock starts. Without it, nothing is received.

Top module: `sync_serial_xcvr`

## Requirements
- R1: In internal-clock mode the shift clock period is 2*(cfg_div+1)*P system cycles, where P is 1, 8 or 32 for cfg_src codes 0, 1 and 2 (code 3 also gives 32). Bytes written back to back follow one another with no change in that period.
- R2: With cfg_clk_pol=0, sdo changes only on falling clock edges and sdi is sampled on rising edges, and the internal clock rests high. With cfg_clk_pol=1 both edges swap and the clock rests low. sdo never changes while no byte is shifting.
- R3: A frame is exactly 8 data bits, bit 0 first, with no framing bits.
- R4: A write makes tx_buf_empty low on the next cycle. The held byte moves to the shifter when the shifter is free (or finishing its last bit) and cfg_tx_en=1, and tx_buf_empty then returns high. This lets a second byte follow the first without a gap.
- R5: tx_empty is high only when nothing is shifting and no byte is held.
- R6: With cfg_txirq_mode=0, tx_irq is set when a held byte moves into the shifter. With mode 1, tx_irq is set when the shifter completes its eighth bit.
- R7: After the eighth sampled bit, with cfg_rx_en=1, the byte appears on rx_rdata and both rx_full and rx_irq are set. A rx_rd pulse clears rx_full. With cfg_rx_en=0 none of these change.
- R8: If a byte completes while rx_full is still high, rx_overrun is set and rx_rdata takes the new byte. rx_rd clears rx_overrun.
- R9: In external-clock mode (cfg_int_clk=0), edges on sclk_in move the shifter only after a byte has been written with cfg_tx_en=1. Both sclk_in and sdi pass through a two-stage synchronizer. The sclk_in frequency must stay at or below one sixth of the system clock.
- R10: Clearing cfg_tx_en lets the current frame finish. After that, no clock edges are produced while a held byte waits, and the clock sits at its resting level. Setting cfg_tx_en again sends the held byte.
- R11: tx_irq and rx_irq remain set until their clear pulse arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_int_clk | input | 1 | 1: generate shift clock, 0: follow sclk_in |
| cfg_src | input | 2 | Prescaler select: 0 /1, 1 /8, 2 and 3 /32 |
| cfg_div | input | 8 | Divider setting n |
| cfg_clk_pol | input | 1 | Edge polarity select |
| cfg_tx_en | input | 1 | Transmit enable |
| cfg_rx_en | input | 1 | Receive enable |
| cfg_txirq_mode | input | 1 | 0: request on holding register empty, 1: request on shift done |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_wdata | input | 8 | Byte to transmit |
| tx_irq_clr | input | 1 | Clears tx_irq |
| rx_rd | input | 1 | Read strobe, consumes rx_rdata |
| rx_irq_clr | input | 1 | Clears rx_irq |
| sclk_in | input | 1 | External shift clock |
| sdi | input | 1 | Serial data in |
| tx_buf_empty | output | 1 | Transmit holding register free |
| tx_empty | output | 1 | No byte held and none shifting |
| tx_irq | output | 1 | Sticky transmit request |
| rx_rdata | output | 8 | Last received byte |
| rx_full | output | 1 | Unread byte present |
| rx_overrun | output | 1 | A byte was overwritten before it was read |
| rx_irq | output | 1 | Sticky receive request |
| sclk_out | output | 1 | Generated shift clock |
| sclk_oe | output | 1 | High when sclk_out should drive the line |
| sdo | output | 1 | Serial data out |

## Verification
Three kinds of internal fault each show at the ports within one frame. A wrong bit counter makes captured bytes rotated or truncated. A wrong prescaler or divider count makes launch-edge spacing differ from 2*(n+1)*P. A wrong phase register makes sdo change on a sampling edge, which is seen on the very next edge. Faults in the holding or flag logic show within one cycle of the write or read strobe: tx_buf_empty, tx_empty, rx_full or rx_overrun take the wrong level. A stuck transmit enable shows as clock edges during the quiet window.

// File: rtl/ssx_pkg.sv
// Shared types for the synchronous serial transceiver.
package ssx_pkg;
    typedef enum logic [1:0] {
        SRC_DIV1      = 2'd0,
        SRC_DIV8      = 2'd1,
        SRC_DIV32     = 2'd2,
        SRC_DIV32_ALT = 2'd3
    } ssx_src_e;

    localparam int PRE_W = 5;

    // Terminal count of the prescaler for each source choice.
    function automatic logic [PRE_W-1:0] pre_limit(input ssx_src_e s);
        case (s)
            SRC_DIV1: pre_limit = 5'd0;
            SRC_DIV8: pre_limit = 5'd7;
            default:  pre_limit = 5'd31;
        endcase
    endfunction
endpackage

// File: rtl/ssx_baud_gen.sv
// Half-period tick generator for the internal shift clock.
// A prescaler (1, 8 or 32) feeds a divider that wraps after div+1 prescaled
// counts, so a tick appears every (div+1)*P cycles.
// Assumes: counters are held at zero while run is low, so the first tick
// always comes a full half period after a transfer starts.
module ssx_baud_gen
    import ssx_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [1:0]       src,
    input  logic [DIV_W-1:0] div,
    output logic             half_tick
);
    logic [PRE_W-1:0] pcnt;
    logic [DIV_W-1:0] dcnt;
    logic             pre_tick;

    // Prescaler terminal count for the selected source.
    assign pre_tick  = (pcnt == pre_limit(ssx_src_e'(src)));
    assign half_tick = run && pre_tick && (dcnt == div);

    // Advance the prescaler and divider while a transfer runs.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pcnt <= '0;
            dcnt <= '0;
        end else begin
            pcnt <= pre_tick ? '0 : pcnt + 1'b1;
            if (pre_tick) begin
                dcnt <= (dcnt == div) ? '0 : dcnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ssx_clk_sync.sv
// Brings the external shift clock and serial input into the system clock
// domain and flags clock edges.
// Assumes: sclk_in toggles no faster than one sixth of clk. The data input
// goes through the same number of stages, so it stays aligned with the
// detected edges.
module ssx_clk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic sdi,
    output logic rise,
    output logic fall,
    output logic sdi_s
);
    logic [STAGES-1:0] ck_q;
    logic [STAGES-1:0] dt_q;
    logic              ck_prev;

    // Shift both lines through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_q    <= '1;
            dt_q    <= '1;
            ck_prev <= 1'b1;
        end else begin
            ck_q[0] <= sclk_in;
            dt_q[0] <= sdi;
            for (int i = 1; i < STAGES; i++) begin
                ck_q[i] <= ck_q[i-1];
                dt_q[i] <= dt_q[i-1];
            end
            ck_prev <= ck_q[STAGES-1];
        end
    end

    assign rise  = ck_q[STAGES-1] & ~ck_prev;
    assign fall  = ~ck_q[STAGES-1] & ck_prev;
    assign sdi_s = dt_q[STAGES-1];
endmodule

// File: rtl/ssx_tx_engine.sv
// Transmit holding register, transmit shifter and frame sequencer.
// Each bit has two events: a launch (drives sdo) and then a sample (the
// receiver captures). Eight such pairs form a frame. In internal mode both
// events come from half-period ticks; in external mode they come from the
// synchronized clock edges picked by the polarity.
// Assumes: a write while the holding register is full replaces its byte.
module ssx_tx_engine #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              int_mode,
    input  logic              pol,
    input  logic              tx_en,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              half_tick,
    input  logic              ext_rise,
    input  logic              ext_fall,
    input  logic              irq_mode,
    input  logic              irq_clr,
    output logic              busy,
    output logic              buf_full,
    output logic              sdo,
    output logic              sclk_line,
    output logic              sample_ev,
    output logic              frame_last,
    output logic              tx_irq
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    logic [DATA_W-1:0] hold_q;
    logic [DATA_W-1:0] shift_q;
    logic [CNT_W-1:0]  bitcnt;
    logic              phase;
    logic              sclk_q;
    logic              idle_lvl;
    logic              launch_src;
    logic              sample_src;
    logic              launch_ev;
    logic              load;

    assign idle_lvl   = ~pol;
    assign launch_src = int_mode ? half_tick : (pol ? ext_rise : ext_fall);
    assign sample_src = int_mode ? half_tick : (pol ? ext_fall : ext_rise);
    assign launch_ev  = busy & ~phase & launch_src;
    assign sample_ev  = busy & phase & sample_src;
    assign frame_last = sample_ev && (bitcnt == LAST_BIT);
    assign load       = buf_full & tx_en & (~busy | frame_last);

    // Holding register: filled by writes, emptied by loads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q   <= '0;
            buf_full <= 1'b0;
        end else if (wr) begin
            hold_q   <= wdata;
            buf_full <= 1'b1;
        end else if (load) begin
            buf_full <= 1'b0;
        end
    end

    // Frame sequencer: load, launch and sample steps of the shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
            busy    <= 1'b0;
            phase   <= 1'b0;
            bitcnt  <= '0;
            sdo     <= 1'b1;
            sclk_q  <= 1'b1;
        end else if (load) begin
            shift_q <= hold_q;
            busy    <= 1'b1;
            phase   <= 1'b0;
            bitcnt  <= '0;
            sclk_q  <= idle_lvl;
        end else if (launch_ev) begin
            sdo     <= shift_q[bitcnt];
            phase   <= 1'b1;
            sclk_q  <= ~idle_lvl;
        end else if (sample_ev) begin
            phase   <= 1'b0;
            bitcnt  <= bitcnt + 1'b1;
            sclk_q  <= idle_lvl;
            if (frame_last) begin
                busy <= 1'b0;
            end
        end else if (!busy) begin
            sclk_q  <= idle_lvl;
        end
    end

    assign sclk_line = (int_mode && busy) ? sclk_q : idle_lvl;

    // Sticky transmit request; a new event wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_irq <= 1'b0;
        end else if (irq_mode ? frame_last : load) begin
            tx_irq <= 1'b1;
        end else if (irq_clr) begin
            tx_irq <= 1'b0;
        end
    end
endmodule

// File: rtl/ssx_rx_engine.sv
// Receive shifter, receive holding register and receive flags.
// Bits arrive first-bit-first into the top of the shifter and move right,
// so after eight samples bit 0 sits in position 0.
// Assumes: the sequencer marks the eighth sample with frame_last.
module ssx_rx_engine #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_ev,
    input  logic              frame_last,
    input  logic              sdi_bit,
    input  logic              rx_en,
    input  logic              rd,
    input  logic              irq_clr,
    output logic [DATA_W-1:0] rdata,
    output logic              full,
    output logic              overrun,
    output logic              rx_irq
);
    logic [DATA_W-1:0] shift_q;
    logic [DATA_W-1:0] next_word;
    logic              commit;

    assign next_word = {sdi_bit, shift_q[DATA_W-1:1]};
    assign commit    = frame_last & rx_en;

    // Capture one bit per sampling event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else if (sample_ev) begin
            shift_q <= next_word;
        end
    end

    // Holding register and full / overrun flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata   <= '0;
            full    <= 1'b0;
            overrun <= 1'b0;
        end else if (commit) begin
            rdata   <= next_word;
            full    <= 1'b1;
            overrun <= full & ~rd;
        end else if (rd) begin
            full    <= 1'b0;
            overrun <= 1'b0;
        end
    end

    // Sticky receive request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_irq <= 1'b0;
        end else if (commit) begin
            rx_irq <= 1'b1;
        end else if (irq_clr) begin
            rx_irq <= 1'b0;
        end
    end
endmodule

// File: rtl/sync_serial_xcvr.sv
// Top of the clock-synchronous serial transceiver.
// Joins the baud generator, the external clock synchronizer and the
// transmit and receive engines. In internal mode sdi is used directly,
// because it is launched from the clock this block generates. In external
// mode sdi comes through the synchronizer.
// Assumes: configuration inputs change only while no frame is in flight.
module sync_serial_xcvr #(
    parameter int DATA_W      = 8,
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_int_clk,
    input  logic [1:0]        cfg_src,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              cfg_clk_pol,
    input  logic              cfg_tx_en,
    input  logic              cfg_rx_en,
    input  logic              cfg_txirq_mode,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_wdata,
    input  logic              tx_irq_clr,
    input  logic              rx_rd,
    input  logic              rx_irq_clr,
    input  logic              sclk_in,
    input  logic              sdi,
    output logic              tx_buf_empty,
    output logic              tx_empty,
    output logic              tx_irq,
    output logic [DATA_W-1:0] rx_rdata,
    output logic              rx_full,
    output logic              rx_overrun,
    output logic              rx_irq,
    output logic              sclk_out,
    output logic              sclk_oe,
    output logic              sdo
);
    logic busy;
    logic buf_full;
    logic half_tick;
    logic ext_rise;
    logic ext_fall;
    logic sdi_s;
    logic sample_ev;
    logic frame_last;
    logic sdi_bit;

    ssx_baud_gen #(.DIV_W(DIV_W)) u_baud (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy & cfg_int_clk),
        .src       (cfg_src),
        .div       (cfg_div),
        .half_tick (half_tick)
    );

    ssx_clk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_in (sclk_in),
        .sdi     (sdi),
        .rise    (ext_rise),
        .fall    (ext_fall),
        .sdi_s   (sdi_s)
    );

    ssx_tx_engine #(.DATA_W(DATA_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .int_mode   (cfg_int_clk),
        .pol        (cfg_clk_pol),
        .tx_en      (cfg_tx_en),
        .wr         (tx_wr),
        .wdata      (tx_wdata),
        .half_tick  (half_tick),
        .ext_rise   (ext_rise),
        .ext_fall   (ext_fall),
        .irq_mode   (cfg_txirq_mode),
        .irq_clr    (tx_irq_clr),
        .busy       (busy),
        .buf_full   (buf_full),
        .sdo        (sdo),
        .sclk_line  (sclk_out),
        .sample_ev  (sample_ev),
        .frame_last (frame_last),
        .tx_irq     (tx_irq)
    );

    assign sdi_bit = cfg_int_clk ? sdi : sdi_s;

    ssx_rx_engine #(.DATA_W(DATA_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_ev  (sample_ev),
        .frame_last (frame_last),
        .sdi_bit    (sdi_bit),
        .rx_en      (cfg_rx_en),
        .rd         (rx_rd),
        .irq_clr    (rx_irq_clr),
        .rdata      (rx_rdata),
        .full       (rx_full),
        .overrun    (rx_overrun),
        .rx_irq     (rx_irq)
    );

    assign tx_buf_empty = ~buf_full;
    assign tx_empty     = ~busy & ~buf_full;
    assign sclk_oe      = cfg_int_clk;
endmodule

// File: rtl/ssx_checker.sv
// Temporal checks on the transceiver, bound to the top module.
module ssx_checker (
    input logic clk,
    input logic rst_n,
    input logic cfg_int_clk,
    input logic cfg_clk_pol,
    input logic cfg_rx_en,
    input logic busy,
    input logic frame_last,
    input logic sclk_out,
    input logic sdo,
    input logic tx_wr,
    input logic tx_buf_empty,
    input logic tx_empty,
    input logic tx_irq,
    input logic tx_irq_clr,
    input logic rx_rd,
    input logic rx_full,
    input logic rx_overrun,
    input logic rx_irq,
    input logic rx_irq_clr
);
    // R2: the generated clock rests at the level set by the polarity.
    p_clk_rest_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_int_clk && !busy) |-> (sclk_out == !cfg_clk_pol));

    // R2: the data output holds while nothing is shifting.
    p_sdo_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(sdo));

    // R4: a write leaves the holding register occupied.
    p_wr_fills_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr |=> !tx_buf_empty);

    // R5: fully idle implies the holding register is free.
    p_empty_implies_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> tx_buf_empty);

    // R7: a read with no frame completing consumes the byte.
    p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd && !frame_last) |=> (!rx_full && !rx_overrun));

    // R7: a byte only arrives while receive is enabled.
    p_rx_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> $past(cfg_rx_en));

    // R8: overrun is only flagged alongside an unread byte.
    p_overrun_with_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |-> rx_full);

    // R11: requests persist until cleared.
    p_txirq_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_irq && !tx_irq_clr) |=> tx_irq);

    p_rxirq_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_irq && !rx_irq_clr) |=> rx_irq);
endmodule

bind sync_serial_xcvr ssx_checker u_chk (.*);

// File: tb/sync_serial_xcvr_tb.sv
module sync_serial_xcvr_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_int_clk, cfg_clk_pol, cfg_tx_en, cfg_rx_en, cfg_txirq_mode;
    logic [1:0] cfg_src;
    logic [7:0] cfg_div;
    logic       tx_wr, tx_irq_clr, rx_rd, rx_irq_clr, sclk_in, sdi_drv, lb;
    logic [7:0] tx_wdata;
    logic       sdi;
    logic       tx_buf_empty, tx_empty, tx_irq, rx_full, rx_overrun, rx_irq;
    logic       sclk_out, sclk_oe, sdo;
    logic [7:0] rx_rdata;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;
    assign sdi = lb ? sdo : sdi_drv;

    sync_serial_xcvr u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_int_clk(cfg_int_clk), .cfg_src(cfg_src),
        .cfg_div(cfg_div), .cfg_clk_pol(cfg_clk_pol), .cfg_tx_en(cfg_tx_en),
        .cfg_rx_en(cfg_rx_en), .cfg_txirq_mode(cfg_txirq_mode), .tx_wr(tx_wr),
        .tx_wdata(tx_wdata), .tx_irq_clr(tx_irq_clr), .rx_rd(rx_rd),
        .rx_irq_clr(rx_irq_clr), .sclk_in(sclk_in), .sdi(sdi),
        .tx_buf_empty(tx_buf_empty), .tx_empty(tx_empty), .tx_irq(tx_irq),
        .rx_rdata(rx_rdata), .rx_full(rx_full), .rx_overrun(rx_overrun),
        .rx_irq(rx_irq), .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sdo(sdo)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_byte(input logic [7:0] b);
        @(negedge clk); tx_wr = 1'b1; tx_wdata = b;
        @(negedge clk); tx_wr = 1'b0;
    endtask

    task automatic rd_byte();
        @(negedge clk); rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); tx_irq_clr = 1'b1; rx_irq_clr = 1'b1;
        @(negedge clk); tx_irq_clr = 1'b0; rx_irq_clr = 1'b0;
    endtask

    // Watch the generated clock: gather nbits sdo values at sampling edges,
    // count launch-edge spacings that differ from exp_per and sdo changes
    // that happen away from a launch edge.
    task automatic collect(input int nbits, input int exp_per,
                           output logic [15:0] bits, output int bad_per,
                           output int stray);
        int cyc = 0;
        int got = 0;
        int prev_l = -1;
        logic idle = ~cfg_clk_pol;
        logic ps = sclk_out;
        logic pd = sdo;
        bits = '0; bad_per = 0; stray = 0;
        while (got < nbits && cyc < 40000) begin
            @(negedge clk);
            cyc++;
            if (sdo != pd && !(ps == idle && sclk_out != idle)) stray++;
            if (ps == idle && sclk_out != idle) begin
                if (prev_l >= 0 && (cyc - prev_l) != exp_per) bad_per++;
                prev_l = cyc;
            end
            if (ps != idle && sclk_out == idle) begin
                bits[got] = sdo;
                got++;
            end
            ps = sclk_out; pd = sdo;
        end
        if (got < nbits) bad_per++;
    endtask

    // Act as the remote clock master for one byte in external mode.
    task automatic ext_frame(input logic pol, input logic [7:0] din,
                             output logic [7:0] dout);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); sclk_in = pol; sdi_drv = din[i];
            repeat (8) @(negedge clk);
            dout[i] = sdo;
            sclk_in = ~pol;
            repeat (8) @(negedge clk);
        end
    endtask

    function automatic int pdiv(input int s);
        return (s == 0) ? 1 : (s == 1) ? 8 : 32;
    endfunction

    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] bits;
        logic [7:0]  dout;
        int bp, st, edges;
        logic psc;
        rst_n = 0; cfg_int_clk = 1; cfg_clk_pol = 0; cfg_tx_en = 1; cfg_rx_en = 1;
        cfg_txirq_mode = 0; cfg_src = 0; cfg_div = 0; tx_wr = 0; tx_wdata = 0;
        tx_irq_clr = 0; rx_rd = 0; rx_irq_clr = 0; sclk_in = 1; sdi_drv = 1; lb = 1;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // Reset state (R5, R2)
        chk("R5 reset tx_empty", tx_empty, 1);
        chk("R4 reset tx_buf_empty", tx_buf_empty, 1);
        chk("R7 reset rx_full", rx_full, 0);
        chk("R11 reset irqs", {tx_irq, rx_irq}, 0);
        chk("R2 reset clock rest high", sclk_out, 1);

        // Sweep of source and divider in loopback, both polarities (R1 R2 R3 R7)
        for (int pol = 0; pol < 2; pol++) begin
            for (int s = 0; s < 3; s++) begin
                for (int k = 0; k < 3; k++) begin
                    int n = (k == 0) ? 0 : (k == 1) ? 2 : 5;
                    logic [7:0] b = 8'h35 + 8'(29 * (pol * 9 + s * 3 + k));
                    cfg_clk_pol = pol[0]; cfg_src = s[1:0]; cfg_div = n[7:0];
                    @(negedge clk);
                    chk("R2 rest level", sclk_out, pol == 0 ? 1 : 0);
                    wr_byte(b);
                    chk("R5 busy after write", tx_empty, 0);
                    collect(8, 2 * (n + 1) * pdiv(s), bits, bp, st);
                    chk("R1 launch spacing errors", bp, 0);
                    chk("R2 sdo off launch edge", st, 0);
                    chk("R3 transmitted byte", bits[7:0], b);
                    repeat (3) @(negedge clk);
                    chk("R7 rx_full", rx_full, 1);
                    chk("R7 received byte", rx_rdata, b);
                    chk("R5 idle after frame", tx_empty, 1);
                    rd_byte();
                    chk("R7 read clears full", rx_full, 0);
                    pulse_clr();
                end
            end
        end
        cfg_clk_pol = 0;

        // Transmit request modes and stickiness (R6 R11)
        cfg_src = 0; cfg_div = 1; cfg_txirq_mode = 0;
        wr_byte(8'hC3);
        @(negedge clk);
        chk("R6 mode0 irq on load", tx_irq, 1);
        collect(8, 4, bits, bp, st);
        repeat (50) @(negedge clk);
        chk("R11 tx_irq held", tx_irq, 1);
        chk("R11 rx_irq held", rx_irq, 1);
        pulse_clr();
        chk("R11 tx_irq cleared", tx_irq, 0);
        chk("R11 rx_irq cleared", rx_irq, 0);
        rd_byte();
        cfg_txirq_mode = 1;
        wr_byte(8'h5A);
        repeat (3) @(negedge clk);
        chk("R6 mode1 no irq mid frame", tx_irq, 0);
        collect(8, 4, bits, bp, st);
        chk("R6 mode1 irq at frame end", tx_irq, 1);
        rd_byte(); pulse_clr(); cfg_txirq_mode = 0;

        // Back-to-back bytes and overrun (R4 R8)
        cfg_src = 1; cfg_div = 1;
        wr_byte(8'h96);
        @(negedge clk);
        chk("R4 held byte moved", tx_buf_empty, 1);
        wr_byte(8'h1E);
        chk("R4 second byte held", tx_buf_empty, 0);
        chk("R5 not empty with held byte", tx_empty, 0);
        collect(16, 32, bits, bp, st);
        chk("R4 gapless spacing", bp, 0);
        chk("R4 first byte", bits[7:0], 8'h96);
        chk("R4 second byte", bits[15:8], 8'h1E);
        repeat (3) @(negedge clk);
        chk("R8 overrun set", rx_overrun, 1);
        chk("R8 newest byte kept", rx_rdata, 8'h1E);
        rd_byte();
        chk("R8 read clears overrun", rx_overrun, 0);
        pulse_clr();

        // Transmit disable mid frame (R10)
        cfg_src = 0; cfg_div = 7;
        wr_byte(8'hE1);
        repeat (2) @(negedge clk);
        cfg_tx_en = 0;
        wr_byte(8'h4B);
        collect(8, 16, bits, bp, st);
        chk("R10 current frame completes", bits[7:0], 8'hE1);
        edges = 0; psc = sclk_out;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (sclk_out != psc) edges++;
            psc = sclk_out;
        end
        chk("R10 no edges while disabled", edges, 0);
        chk("R10 clock at rest", sclk_out, 1);
        chk("R10 byte still held", tx_buf_empty, 0);
        cfg_tx_en = 1;
        collect(8, 16, bits, bp, st);
        chk("R10 held byte sent on enable", bits[7:0], 8'h4B);
        repeat (3) @(negedge clk);
        rd_byte(); pulse_clr();

        // Receive disabled (R7)
        cfg_rx_en = 0; cfg_div = 0;
        wr_byte(8'h77);
        collect(8, 2, bits, bp, st);
        repeat (3) @(negedge clk);
        chk("R7 rx off keeps empty", rx_full, 0);
        chk("R7 rx off no request", rx_irq, 0);
        cfg_rx_en = 1;

        // External clock mode (R9)
        lb = 0; cfg_int_clk = 0; cfg_clk_pol = 0; sclk_in = 1;
        repeat (4) @(negedge clk);
        chk("R9 no clock drive", sclk_oe, 0);
        ext_frame(1'b0, 8'h3C, dout);
        repeat (6) @(negedge clk);
        chk("R9 nothing without dummy write", rx_full, 0);
        wr_byte(8'hA6);
        ext_frame(1'b0, 8'h3C, dout);
        repeat (6) @(negedge clk);
        chk("R9 received byte pol0", rx_rdata, 8'h3C);
        chk("R9 rx_full pol0", rx_full, 1);
        chk("R9 sent dummy byte pol0", dout, 8'hA6);
        rd_byte(); pulse_clr();
        cfg_clk_pol = 1; sclk_in = 0;
        repeat (6) @(negedge clk);
        wr_byte(8'h71);
        ext_frame(1'b1, 8'hC9, dout);
        repeat (6) @(negedge clk);
        chk("R9 received byte pol1", rx_rdata, 8'hC9);
        chk("R9 sent byte pol1", dout, 8'h71);
        chk("R5 idle after external frame", tx_empty, 1);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule